// File: doc/BRIEF.md
# Watchpoint Comparator Bank with Linked Data-Value Match

This block watches a core's bus accesses and its program-counter stream against four programmable comparators. Each comparator holds a reference value, an ignore-size field and a function word. The function word chooses what a match does: raise a trace-emit strobe (PC, data value or address offset), request a debug halt, or pulse a trace trigger. Comparator 0 may watch the free-running cycle count instead of addresses. Comparator 1 may compare the data value of an access, with one or two other comparators acting as its address qualifiers.

Software programs the comparators through a simple write port that selects a comparator and one of its three registers. Every comparator has a sticky match flag that software clears by reading it. All strobes and flags are registered and appear in the cycle after the access, PC sample or cycle count that caused them. Packing trace data into packets is left to a downstream unit.

Top module: `wpt_unit`

## Requirements
- R1: An access hits comparator i when some byte it touches equals the reference once the low `mask` bits of both are ignored (mask 0..15). The access is acc_size bytes (0 = 1, 1 = 2, 2 or 3 = 4), aligned down to its size. For example, a reference of 3 is hit by a word access at address 0 but not by a byte access at address 0.
- R2: Function code 4 asserts act_halt and code 8 asserts act_trig when pc_valid is high and pc_value equals the reference with the low `mask` bits ignored. The function word is laid out as: bits 3:0 code, bit 4 offset-instead-of-PC, bit 5 cycle mode, bit 6 data mode, bits 9:8 data size, bits 13:10 first link, bits 17:14 second link.
- R3: Codes 5, 6 and 7 request a halt, and codes 9, 10 and 11 pulse a trigger, on a hitting read, write or either, in that order (acc_write = 1 marks a write).
- R4: The emit codes act on a hitting access. Codes 1, 2 and 3 take either direction; codes 12 and 14 take reads only, and 13 and 15 writes only. Codes 1, 3, 14 and 15 emit the PC, and codes 2, 3, 12 to 15 emit data. With bit 4 set, act_offs replaces the PC strobe, and it also replaces the data strobe for codes 12 and 13.
- R5: A data strobe is never raised for a faulting access (acc_fault = 1). A PC strobe ignores acc_fault but fires only when acc_first = 1.
- R6: Code 0 disables a comparator: it raises no strobe.
- R7: With bit 5 set in comparator 0's function word, comparator 0 ignores accesses and the PC. It treats cyc_count, equal to its reference with low `mask` bits ignored, as its PC-match event. On other comparators bit 5 cannot be written and has no effect.
- R8: With bit 6 set in comparator 1's function word, comparator 1 hits on a non-faulting access whose data equals its reference and whose address hits the comparator named by the first link. Data is compared on 8 bits for size 0, on 16 bits for size 1, and on 32 bits for sizes 2 and 3. Comparator 1 then has no PC event. Linked comparators other than 1 raise no strobes while so named. Bits 6 to 17 can be written only on comparator 1.
- R9: When parameter LINK2_EN is 1, an address hit on the comparator named by the second link also qualifies the data match. Link values of 4 and above name no comparator.
- R10: matched[i] sets in the cycle any strobe of comparator i is raised and stays set until a cycle with flag_rd[i] = 1. A read and a new match in the same cycle leave it set.
- R11: Reset clears every reference, mask, function word, strobe and flag. Config registers are selected by cfg_reg: 0 reference, 1 mask (bits 3:0), 2 function word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Comparator selected for the write |
| cfg_reg | input | 2 | Register selected: 0 reference, 1 mask, 2 function |
| cfg_wdata | input | 32 | Write data |
| flag_rd | input | 4 | Per-comparator read of the match flag (clears it) |
| acc_valid | input | 1 | A bus access is present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_fault | input | 1 | Access faulted |
| acc_first | input | 1 | First beat of a burst |
| acc_size | input | 2 | Access size code |
| acc_addr | input | 32 | Access address |
| acc_data | input | 32 | Access data, right-aligned |
| pc_valid | input | 1 | PC sample present |
| pc_value | input | 32 | Executed instruction address |
| cyc_count | input | 32 | Free-running cycle count |
| act_pc | output | 4 | Emit-PC strobe per comparator |
| act_data | output | 4 | Emit-data strobe per comparator |
| act_offs | output | 4 | Emit-address-offset strobe per comparator |
| act_halt | output | 4 | Halt request per comparator |
| act_trig | output | 4 | Trace trigger per comparator |
| matched | output | 4 | Sticky match flags |

## Verification
Assertions watch the flag rules on every cycle: a strobe always implies a set flag, a flag holds until it is read, and a read with no new match clears it. On every cycle they also check that the PC and offset strobes of a comparator never coincide, that a faulting access yields no data strobe, and that a comparator named as a data-match link stays quiet. The mask and byte-coverage arithmetic, the sixteen function codes, cycle mode, data-size selection and the second link can only be shown by the bench's directed and random scenarios, which compare every strobe against an independent byte-by-byte model.

// File: rtl/wpt_unit.sv
module wpt_unit #(
  parameter int NCMP = 4,
  parameter int W = 32,
  parameter bit LINK2_EN = 1'b1,
  localparam int SW = $clog2(NCMP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_sel,
  input  logic [1:0]      cfg_reg,
  input  logic [W-1:0]    cfg_wdata,
  input  logic [NCMP-1:0] flag_rd,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic            acc_fault,
  input  logic            acc_first,
  input  logic [1:0]      acc_size,
  input  logic [W-1:0]    acc_addr,
  input  logic [W-1:0]    acc_data,
  input  logic            pc_valid,
  input  logic [W-1:0]    pc_value,
  input  logic [W-1:0]    cyc_count,
  output logic [NCMP-1:0] act_pc,
  output logic [NCMP-1:0] act_data,
  output logic [NCMP-1:0] act_offs,
  output logic [NCMP-1:0] act_halt,
  output logic [NCMP-1:0] act_trig,
  output logic [NCMP-1:0] matched
);
  localparam int FW = 18;

  logic [W-1:0]  ref_q [NCMP];
  logic [3:0]    msk_q [NCMP];
  logic [FW-1:0] fn_q  [NCMP];

  logic [NCMP-1:0] n_pc, n_data, n_offs, n_halt, n_trig, n_any;
  logic [15:0] ahit;
  logic [1:0]  sl;
  logic        dm, qual, dv_hit;
  logic [3:0]  lk0, lk1;
  logic [1:0]  dsz;

  function automatic logic [FW-1:0] fn_keep(int i);
    if (i == 0) return 18'h0003F;
    if (i == 1) return 18'h3FF5F;
    return 18'h0001F;
  endfunction

  assign sl  = (acc_size == 2'd3) ? 2'd2 : acc_size;
  assign dm  = fn_q[1][6];
  assign dsz = fn_q[1][9:8];
  assign lk0 = fn_q[1][13:10];
  assign lk1 = fn_q[1][17:14];

  for (genvar g = 0; g < NCMP; g++) begin : g_addr
    logic [3:0] eff;
    assign eff = (msk_q[g] > {2'b0, sl}) ? msk_q[g] : {2'b0, sl};
    assign ahit[g] = ((acc_addr ^ ref_q[g]) >> eff) == '0;
  end
  if (NCMP < 16) begin : g_pad
    assign ahit[15:NCMP] = '0;
  end

  assign qual   = ahit[lk0] | (LINK2_EN & ahit[lk1]);
  assign dv_hit = (dsz == 2'd0) ? (acc_data[7:0] == ref_q[1][7:0]) :
                  (dsz == 2'd1) ? (acc_data[15:0] == ref_q[1][15:0]) :
                                  (acc_data == ref_q[1]);

  always_comb begin
    logic cyc, ovr, ah, pe, rd, wr, ev, wp, wd, h, t, er;
    logic [3:0] code;
    for (int i = 0; i < NCMP; i++) begin
      cyc  = (i == 0) && fn_q[i][5];
      ovr  = dm && (i != 1) && (lk0 == 4'(i) || (LINK2_EN && lk1 == 4'(i)));
      if (i == 1 && dm) ah = acc_valid && !acc_fault && qual && dv_hit;
      else              ah = acc_valid && ahit[i] && !cyc;
      if (cyc) pe = ((cyc_count ^ ref_q[i]) >> msk_q[i]) == '0;
      else     pe = pc_valid && !(i == 1 && dm) && (((pc_value ^ ref_q[i]) >> msk_q[i]) == '0);
      rd   = ah && !acc_write;
      wr   = ah && acc_write;
      code = fn_q[i][3:0];
      er   = fn_q[i][4];
      ev = 1'b0; wp = 1'b0; wd = 1'b0; h = 1'b0; t = 1'b0;
      case (code)
        4'd1:  begin ev = ah; wp = 1'b1; end
        4'd2:  begin ev = ah; wd = 1'b1; end
        4'd3:  begin ev = ah; wp = 1'b1; wd = 1'b1; end
        4'd4:  h = pe;
        4'd5:  h = rd;
        4'd6:  h = wr;
        4'd7:  h = ah;
        4'd8:  t = pe;
        4'd9:  t = rd;
        4'd10: t = wr;
        4'd11: t = ah;
        4'd12: begin ev = rd; wd = !er; end
        4'd13: begin ev = wr; wd = !er; end
        4'd14: begin ev = rd; wp = 1'b1; wd = 1'b1; end
        4'd15: begin ev = wr; wp = 1'b1; wd = 1'b1; end
        default: ;
      endcase
      n_pc[i]   = ev && wp && !er && acc_first && !ovr;
      n_data[i] = ev && wd && !acc_fault && !ovr;
      n_offs[i] = ev && er && !ovr;
      n_halt[i] = h && !ovr;
      n_trig[i] = t && !ovr;
    end
  end

  assign n_any = n_pc | n_data | n_offs | n_halt | n_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCMP; i++) begin
        ref_q[i] <= '0;
        msk_q[i] <= '0;
        fn_q[i]  <= '0;
      end
      act_pc <= '0; act_data <= '0; act_offs <= '0;
      act_halt <= '0; act_trig <= '0; matched <= '0;
    end else begin
      for (int i = 0; i < NCMP; i++) begin
        if (cfg_we && cfg_sel == SW'(i)) begin
          case (cfg_reg)
            2'd0: ref_q[i] <= cfg_wdata;
            2'd1: msk_q[i] <= cfg_wdata[3:0];
            2'd2: fn_q[i]  <= cfg_wdata[FW-1:0] & fn_keep(i);
            default: ;
          endcase
        end
      end
      act_pc   <= n_pc;
      act_data <= n_data;
      act_offs <= n_offs;
      act_halt <= n_halt;
      act_trig <= n_trig;
      matched  <= (matched & ~flag_rd) | n_any;
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_chk
    assert_flag_on_act_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (act_pc[g] | act_data[g] | act_offs[g] | act_halt[g] | act_trig[g]) |-> matched[g]);
    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (matched[g] && !flag_rd[g]) |=> matched[g]);
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd[g] && !n_any[g]) |=> !matched[g]);
    assert_pc_or_offs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_pc[g] && act_offs[g]));
    assert_fault_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_fault) |=> !act_data[g]);
    if (g != 1) begin : g_ovr
      assert_link_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_q[1][6] && fn_q[1][13:10] == 4'(g)) |=>
        !(act_pc[g] | act_data[g] | act_offs[g] | act_halt[g] | act_trig[g]));
    end
  end
endmodule

// File: tb/wpt_unit_tb.sv
module wpt_unit_tb;
  localparam int N = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0, cfg_reg = '0;
  logic [31:0] cfg_wdata = '0;
  logic [N-1:0] flag_rd = '0;
  logic acc_valid = 0, acc_write = 0, acc_fault = 0, acc_first = 0;
  logic [1:0] acc_size = '0;
  logic [31:0] acc_addr = '0, acc_data = '0;
  logic pc_valid = 0;
  logic [31:0] pc_value = '0, cyc_count = 32'hFFFF_0000;
  logic [N-1:0] act_pc, act_data, act_offs, act_halt, act_trig, matched;

  wpt_unit u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] m_ref [N];
  logic [3:0]  m_msk [N];
  logic [17:0] m_fn  [N];
  logic [N-1:0] m_flags;

  function automatic bit covers(int j);
    int n;
    logic [31:0] base;
    if (j >= N) return 0;
    n = 1 << ((acc_size == 2'd3) ? 2 : acc_size);
    base = acc_addr & ~(32'(n) - 1);
    for (int k = 0; k < n; k++)
      if ((((base + 32'(k)) ^ m_ref[j]) >> m_msk[j]) == 0) return 1;
    return 0;
  endfunction

  function automatic logic [4:0] exp_act(int i);
    logic [17:0] f;
    bit dmode, cyc, hit, pev, rdh, wrh, er, ev, wpc, wdat, halt, trig;
    int c, l0, l1;
    logic [31:0] dm;
    f = m_fn[i]; c = int'(f[3:0]); er = f[4];
    dmode = m_fn[1][6]; l0 = int'(m_fn[1][13:10]); l1 = int'(m_fn[1][17:14]);
    if (i != 1 && dmode && (l0 == i || (l1 == i))) return 5'b0;
    cyc = (i == 0) && f[5];
    dm = (m_fn[1][9:8] == 0) ? 32'hFF : (m_fn[1][9:8] == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (cyc) hit = 0;
    else if (i == 1 && dmode)
      hit = acc_valid && !acc_fault && (covers(l0) || covers(l1)) && ((acc_data & dm) == (m_ref[1] & dm));
    else hit = acc_valid && covers(i);
    if (cyc) pev = ((cyc_count ^ m_ref[0]) >> m_msk[0]) == 0;
    else pev = pc_valid && !(i == 1 && dmode) && (((pc_value ^ m_ref[i]) >> m_msk[i]) == 0);
    rdh = hit && !acc_write; wrh = hit && acc_write;
    halt = (c == 4 && pev) || (c == 5 && rdh) || (c == 6 && wrh) || (c == 7 && hit);
    trig = (c == 8 && pev) || (c == 9 && rdh) || (c == 10 && wrh) || (c == 11 && hit);
    ev = (c >= 1 && c <= 3) ? hit : (c == 12 || c == 14) ? rdh : (c == 13 || c == 15) ? wrh : 0;
    wpc = (c == 1 || c == 3 || c == 14 || c == 15);
    wdat = (c == 2 || c == 3 || c >= 12) && !(er && (c == 12 || c == 13));
    return {ev && wpc && !er && acc_first, ev && wdat && !acc_fault, ev && er, halt, trig};
  endfunction

  task automatic tick(string tag);
    logic [N-1:0] e_pc, e_dt, e_of, e_ht, e_tg, e_fl;
    logic [4:0] a;
    for (int i = 0; i < N; i++) begin
      a = exp_act(i);
      {e_pc[i], e_dt[i], e_of[i], e_ht[i], e_tg[i]} = a;
    end
    e_fl = (m_flags & ~flag_rd) | e_pc | e_dt | e_of | e_ht | e_tg;
    if (cfg_we) begin
      case (cfg_reg)
        2'd0: m_ref[cfg_sel] = cfg_wdata;
        2'd1: m_msk[cfg_sel] = cfg_wdata[3:0];
        2'd2: m_fn[cfg_sel] = cfg_wdata[17:0] &
              ((cfg_sel == 0) ? 18'h0003F : (cfg_sel == 1) ? 18'h3FF5F : 18'h0001F);
        default: ;
      endcase
    end
    @(posedge clk); #1;
    m_flags = e_fl;
    checks++;
    if ({act_pc, act_data, act_offs, act_halt, act_trig, matched} !==
        {e_pc, e_dt, e_of, e_ht, e_tg, e_fl}) begin
      fails++;
      $display("FAIL %s: got pc=%b dat=%b off=%b hlt=%b trg=%b flg=%b exp pc=%b dat=%b off=%b hlt=%b trg=%b flg=%b",
               tag, act_pc, act_data, act_offs, act_halt, act_trig, matched,
               e_pc, e_dt, e_of, e_ht, e_tg, e_fl);
    end
  endtask

  task automatic idle();
    acc_valid = 0; pc_valid = 0; flag_rd = '0; cfg_we = 0; acc_fault = 0;
  endtask

  task automatic setcfg(int i, int r, logic [31:0] v, string tag);
    idle();
    cfg_we = 1; cfg_sel = 2'(i); cfg_reg = 2'(r); cfg_wdata = v;
    tick(tag);
    cfg_we = 0;
  endtask

  task automatic acc(logic [31:0] a, int sz, bit w, logic [31:0] d, bit flt, bit first, string tag);
    idle();
    acc_valid = 1; acc_addr = a; acc_size = 2'(sz); acc_write = w;
    acc_data = d; acc_fault = flt; acc_first = first;
    tick(tag);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    for (int i = 0; i < N; i++) begin m_ref[i] = 0; m_msk[i] = 0; m_fn[i] = 0; end
    m_flags = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    checks++;
    if ({act_pc, act_data, act_offs, act_halt, act_trig, matched} !== '0) begin
      fails++;
      $display("FAIL R11 reset: got %b exp 0", {act_pc, act_data, act_offs, act_halt, act_trig, matched});
    end

    setcfg(2, 0, 32'h3, "R11 cfg ref");
    setcfg(2, 2, 32'h5, "R11 cfg fn");
    acc(32'h0, 2, 0, 0, 0, 1, "R1 word at 0 covers ref 3");
    acc(32'h0, 0, 0, 0, 0, 1, "R1 byte at 0 misses ref 3");
    acc(32'h3, 0, 0, 0, 0, 1, "R1 byte at 3 hits");
    acc(32'h0, 2, 1, 0, 0, 1, "R3 write ignored by read watch");
    setcfg(2, 2, 32'h6, "R3 cfg write watch");
    acc(32'h0, 2, 1, 0, 0, 1, "R3 write watch hits");
    setcfg(2, 2, 32'hA, "R3 cfg trig write");
    acc(32'h2, 1, 1, 0, 0, 1, "R3 trigger on write");
    setcfg(2, 0, 32'h13, "R1 cfg ref");
    setcfg(2, 1, 32'h4, "R1 cfg mask");
    setcfg(2, 2, 32'h7, "R1 cfg fn");
    acc(32'h1F, 0, 0, 0, 0, 1, "R1 masked hit");
    acc(32'h20, 0, 0, 0, 0, 1, "R1 masked miss");
    setcfg(2, 2, 32'h0, "R6 cfg off");
    acc(32'h10, 0, 0, 0, 0, 1, "R6 disabled quiet");

    setcfg(3, 0, 32'h200, "R2 cfg ref");
    setcfg(3, 2, 32'h4, "R2 cfg halt");
    idle(); pc_valid = 1; pc_value = 32'h200; tick("R2 pc halt");
    setcfg(3, 2, 32'h8, "R2 cfg trig");
    idle(); pc_valid = 1; pc_value = 32'h200; tick("R2 pc trigger");
    idle(); pc_valid = 1; pc_value = 32'h204; tick("R2 pc miss");

    setcfg(2, 0, 32'h40, "R4 cfg");
    setcfg(2, 1, 32'h0, "R4 cfg");
    setcfg(2, 2, 32'h1, "R4 cfg emit pc");
    acc(32'h40, 2, 0, 0, 0, 1, "R4 emit pc");
    setcfg(2, 2, 32'h11, "R4 cfg offset");
    acc(32'h40, 2, 0, 0, 0, 1, "R4 offset replaces pc");
    setcfg(2, 2, 32'h1C, "R4 cfg read offset");
    acc(32'h40, 2, 0, 0, 0, 1, "R4 code 12 offset only");
    acc(32'h40, 2, 1, 0, 0, 1, "R4 code 12 ignores write");
    setcfg(2, 2, 32'h3, "R5 cfg");
    acc(32'h40, 2, 0, 0, 1, 1, "R5 fault keeps pc drops data");
    acc(32'h40, 2, 0, 0, 0, 0, "R5 non-first beat no pc");

    setcfg(0, 0, 32'd100, "R7 cfg");
    setcfg(0, 2, 32'h24, "R7 cfg cycle");
    idle(); cyc_count = 32'd100; tick("R7 cycle match");
    cyc_count = 32'd101; tick("R7 cycle miss");
    setcfg(2, 2, 32'h24, "R7 bit ignored elsewhere");
    idle(); cyc_count = 32'h40; tick("R7 cmp2 ignores cycle");
    cyc_count = 32'hFFFF_0000;
    setcfg(0, 2, 32'h0, "R7 cfg off");

    setcfg(1, 0, 32'hAB, "R8 cfg");
    setcfg(2, 2, 32'h6, "R8 cfg cmp2");
    setcfg(1, 2, 32'h6 | 32'h40 | (32'd2 << 10) | (32'd15 << 14), "R8 cfg dm");
    acc(32'h40, 2, 1, 32'h12AB, 0, 1, "R8 data byte match, link overridden");
    acc(32'h40, 2, 1, 32'h12AC, 0, 1, "R8 data mismatch");
    acc(32'h40, 2, 1, 32'h12AB, 1, 1, "R8 faulting access");
    setcfg(1, 2, 32'h6 | 32'h40 | (32'd1 << 8) | (32'd2 << 10) | (32'd15 << 14), "R8 cfg half");
    acc(32'h40, 2, 1, 32'h12AB, 0, 1, "R8 halfword mismatch");
    acc(32'h40, 2, 1, 32'h00AB, 0, 1, "R8 halfword match");
    setcfg(3, 0, 32'h80, "R9 cfg");
    setcfg(3, 1, 32'h0, "R9 cfg");
    setcfg(1, 2, 32'h6 | 32'h40 | (32'd2 << 10) | (32'd3 << 14), "R9 cfg link2");
    acc(32'h80, 2, 1, 32'hAB, 0, 1, "R9 second link qualifies");

    idle(); flag_rd = 4'b0010; tick("R10 read clears flag");
    acc(32'h80, 2, 1, 32'hAB, 0, 1, "R10 set again");
    flag_rd = 4'b0010; tick("R10 read with match keeps flag");
    idle(); flag_rd = 4'b1111; tick("R10 clear all");

    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom % 8 == 0) begin
        cfg_we = 1; cfg_sel = 2'($urandom % 4); cfg_reg = 2'($urandom % 3);
        case (cfg_reg)
          2'd0: cfg_wdata = $urandom & 32'hFF;
          2'd1: cfg_wdata = $urandom % 6;
          default: cfg_wdata = ($urandom & 32'h3F) | (($urandom % 4 == 0) ? 32'h40 : 0) |
                               (32'($urandom % 4) << 8) | (32'($urandom % 5) << 10) |
                               (32'($urandom % 5) << 14);
        endcase
      end
      acc_valid = ($urandom % 10) < 7;
      acc_addr = $urandom & 32'hFF; acc_size = 2'($urandom % 4);
      acc_write = $urandom % 2; acc_fault = ($urandom % 5) == 0; acc_first = ($urandom % 3) != 0;
      acc_data = ($urandom % 3 == 0) ? m_ref[1] : $urandom;
      pc_valid = $urandom % 2; pc_value = $urandom & 32'hFF;
      cyc_count = $urandom & 32'hFF;
      for (int i = 0; i < N; i++) flag_rd[i] = ($urandom % 4) == 0;
      tick("R1-mix random");
      cfg_we = 0;
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule